// File: doc/BRIEF.md
# Streaming Hamming parity generator

This block produces NAND-flash style Hamming parity over a byte stream that flows past it on a parallel data path. Every accepted byte adds to two kinds of parity. Its row parity, the XOR of its eight bits, is steered into a pair of line-parity bits for each bit of the byte's position in the stream. The byte itself is XORed into a running column accumulator, and six column-parity bits are taken from that accumulator.

Software, or a controller that stands in for it, pulses a clear strobe to start a calculation. The strobe also picks one of two layouts. In the first, the block builds two separate codes over two consecutive 256-byte halves. In the second, it builds one code over all 512 bytes. After the 512th accepted byte the block stops, raises a done flag and keeps its six result bytes frozen until the next clear strobe.

Top module: `ecc_stream_gen`

## Requirements
- R1: After rst_n is released, all six result bytes read zero and done is low. Bytes offered before the first clear strobe are not folded in.
- R2: A cycle with ecc_clr high does three things: the six result bytes read zero on the next cycle, done is low, and a new 512-byte calculation is armed. A byte offered in that same cycle is not folded in, and mode_wide is sampled in that cycle.
- R3: Only cycles with in_valid high contribute a byte. Idle cycles in between change nothing and are not counted.
- R4: Column parity is placed in col byte bits [7:2] as {c5,c4,c3,c2,c1,c0}. Each bit is the XOR, over every byte of the code, of these data bits: c0 of bits 0,2,4,6; c1 of bits 1,3,5,7; c2 of bits 0,1,4,5; c3 of bits 2,3,6,7; c4 of bits 0..3; c5 of bits 4..7.
- R5: For address bit k of a byte's position inside its code, line bit 2k is the XOR of the row parities of the bytes whose bit k is 0, and line bit 2k+1 is the XOR for the bytes whose bit k is 1. line_lo carries line bits [7:0] and line_hi carries line bits [15:8]. Bits are stored non-inverted.
- R6: With mode_wide low at the strobe, bytes 0..255 form code 0 (blk0_*) and bytes 256..511 form code 1 (blk1_*). Each code uses an 8-bit position within its half, and bits [1:0] of both col bytes are zero.
- R7: With mode_wide high at the strobe, all 512 bytes form code 0 with a 9-bit position. Line bits 17:16 (the pair for position bit 8, odd above even) sit in blk0_col[1:0], and all three blk1_* bytes stay zero.
- R8: Once 512 bytes have been accepted, further bytes are ignored and all result bytes hold until the next clear strobe.
- R9: done is low while fewer than 512 bytes have been accepted. It is high from the cycle after the 512th accepted byte until a clear strobe.
- R10: A change of mode_wide between two clear strobes does not affect the calculation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_clr | input | 1 | Clear strobe: zero the results, arm a calculation and sample the mode |
| mode_wide | input | 1 | 1 = one 512-byte code, 0 = two 256-byte codes |
| in_valid | input | 1 | A byte is transferred this cycle |
| in_data | input | 8 | Byte being transferred |
| blk0_line_hi | output | 8 | Code 0 line parity bits [15:8] |
| blk0_line_lo | output | 8 | Code 0 line parity bits [7:0] |
| blk0_col | output | 8 | Code 0 column parity [7:2], extra line bits [1:0] in wide mode |
| blk1_line_hi | output | 8 | Code 1 line parity bits [15:8] |
| blk1_line_lo | output | 8 | Code 1 line parity bits [7:0] |
| blk1_col | output | 8 | Code 1 column parity [7:2], bits [1:0] zero |
| done | output | 1 | 512 bytes have been folded in since the last clear strobe |

## Verification
A miscounted position shows up as line parity in the wrong pair, and a wrong lane split puts parity in the wrong code. Either fault appears in the result bytes on the cycle after the byte concerned, and it is certain to be seen once all 512 bytes have arrived. A single nonzero byte swept across positions in both modes pins down each address bit and each lane on its own. A stop point that is off by one shows as done rising a cycle early or late, or as result bytes that keep changing when extra bytes follow the 512th.

// File: rtl/ecc_stream_pkg.sv
package ecc_stream_pkg;

   localparam int BYTE_W    = 8;
   localparam int LINE_BITS = 18;
   localparam int PAIRS     = LINE_BITS / 2;

   typedef logic [BYTE_W-1:0] ecc_byte_t;

   // Six column parity bits from the XOR of all bytes of a code
   function automatic logic [5:0] col_pairs(input ecc_byte_t acc);
      logic [5:0] cp;
      cp[0] = acc[0] ^ acc[2] ^ acc[4] ^ acc[6];
      cp[1] = acc[1] ^ acc[3] ^ acc[5] ^ acc[7];
      cp[2] = acc[0] ^ acc[1] ^ acc[4] ^ acc[5];
      cp[3] = acc[2] ^ acc[3] ^ acc[6] ^ acc[7];
      cp[4] = ^acc[3:0];
      cp[5] = ^acc[7:4];
      return cp;
   endfunction

endpackage

// File: rtl/ecc_stream_ctl.sv
module ecc_stream_ctl #(
   parameter int TOTAL_BYTES = 512,
   parameter int AW          = $clog2(TOTAL_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          mode_in,
   input  logic          in_valid,
   output logic          take,
   output logic [AW-1:0] pos,
   output logic          lane_sel,
   output logic          mode_q,
   output logic          busy,
   output logic          done
);

   localparam logic [AW-1:0] LAST = AW'(TOTAL_BYTES - 1);

   logic          armed_q;
   logic [AW-1:0] cnt_q;

   assign busy     = armed_q;
   assign take     = in_valid & armed_q & ~clr;
   assign pos      = cnt_q;
   assign lane_sel = mode_q ? 1'b0 : cnt_q[AW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         done    <= 1'b0;
         mode_q  <= 1'b0;
      end else if (clr) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
         done    <= 1'b0;
         mode_q  <= mode_in;
      end else if (take) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST) begin
            armed_q <= 1'b0;
            done    <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ecc_byte_fold.sv
module ecc_byte_fold #(
   parameter int DATA_W = 8,
   parameter int AW     = 9
) (
   input  logic [DATA_W-1:0] data,
   input  logic [AW-1:0]     pos,
   output logic [AW-1:0]     hit_odd,
   output logic [AW-1:0]     hit_even
);

   logic rp;
   assign rp = ^data;

   for (genvar k = 0; k < AW; k++) begin : g_addr
      assign hit_odd[k]  = rp &  pos[k];
      assign hit_even[k] = rp & ~pos[k];
   end

endmodule

// File: rtl/ecc_lane_acc.sv
module ecc_lane_acc #(
   parameter int DATA_W = 8,
   parameter int AW     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [DATA_W-1:0] data,
   input  logic [AW-1:0]     hit_odd,
   input  logic [AW-1:0]     hit_even,
   output logic [DATA_W-1:0] col_q,
   output logic [AW-1:0]     odd_q,
   output logic [AW-1:0]     even_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         odd_q  <= '0;
         even_q <= '0;
      end else if (clr) begin
         col_q  <= '0;
         odd_q  <= '0;
         even_q <= '0;
      end else if (en) begin
         col_q  <= col_q ^ data;
         odd_q  <= odd_q ^ hit_odd;
         even_q <= even_q ^ hit_even;
      end
   end

endmodule

// File: rtl/ecc_code_format.sv
module ecc_code_format
   import ecc_stream_pkg::*;
#(
   parameter int LANE_AW = 8,
   parameter int AW      = LANE_AW + 1
) (
   input  ecc_byte_t     col,
   input  logic [AW-1:0] odd,
   input  logic [AW-1:0] even,
   input  logic          wide,
   output ecc_byte_t     line_hi,
   output ecc_byte_t     line_lo,
   output ecc_byte_t     col_byte
);

   logic [LINE_BITS-1:0] line;

   for (genvar k = 0; k < PAIRS; k++) begin : g_pair
      if (k < LANE_AW) begin : g_lane
         assign line[2*k]   = even[k];
         assign line[2*k+1] = odd[k];
      end else if (k == LANE_AW) begin : g_top
         assign line[2*k]   = wide & even[k];
         assign line[2*k+1] = wide & odd[k];
      end else begin : g_pad
         assign line[2*k]   = 1'b0;
         assign line[2*k+1] = 1'b0;
      end
   end

   assign line_lo  = line[7:0];
   assign line_hi  = line[15:8];
   assign col_byte = {col_pairs(col), line[17:16]};

endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
   import ecc_stream_pkg::*;
#(
   parameter int LANE_BYTES = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ecc_clr,
   input  logic       mode_wide,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   output logic [7:0] blk0_line_hi,
   output logic [7:0] blk0_line_lo,
   output logic [7:0] blk0_col,
   output logic [7:0] blk1_line_hi,
   output logic [7:0] blk1_line_lo,
   output logic [7:0] blk1_col,
   output logic       done
);

   localparam int LANES   = 2;
   localparam int TOTAL   = LANE_BYTES * LANES;
   localparam int LANE_AW = $clog2(LANE_BYTES);
   localparam int AW      = LANE_AW + 1;

   if (LANE_BYTES < 2 || LANE_BYTES > 256) begin : g_bad_size
      $error("LANE_BYTES must lie in 2..256");
   end
   if ((1 << LANE_AW) != LANE_BYTES) begin : g_bad_pow2
      $error("LANE_BYTES must be a power of two");
   end

   logic          take;
   logic [AW-1:0] pos;
   logic          lane_sel;
   logic          mode_q;
   logic          busy;
   logic [AW-1:0] hit_odd;
   logic [AW-1:0] hit_even;

   ecc_byte_t     col_q  [LANES];
   logic [AW-1:0] odd_q  [LANES];
   logic [AW-1:0] even_q [LANES];
   ecc_byte_t     o_hi   [LANES];
   ecc_byte_t     o_lo   [LANES];
   ecc_byte_t     o_col  [LANES];

   ecc_stream_ctl #(.TOTAL_BYTES(TOTAL), .AW(AW)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ecc_clr),
      .mode_in  (mode_wide),
      .in_valid (in_valid),
      .take     (take),
      .pos      (pos),
      .lane_sel (lane_sel),
      .mode_q   (mode_q),
      .busy     (busy),
      .done     (done)
   );

   ecc_byte_fold #(.DATA_W(BYTE_W), .AW(AW)) u_fold (
      .data     (in_data),
      .pos      (pos),
      .hit_odd  (hit_odd),
      .hit_even (hit_even)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic en;
      logic wide;
      assign en   = take & (lane_sel == 1'(g));
      assign wide = (g == 0) ? mode_q : 1'b0;

      ecc_lane_acc #(.DATA_W(BYTE_W), .AW(AW)) u_acc (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (ecc_clr),
         .en       (en),
         .data     (in_data),
         .hit_odd  (hit_odd),
         .hit_even (hit_even),
         .col_q    (col_q[g]),
         .odd_q    (odd_q[g]),
         .even_q   (even_q[g])
      );

      ecc_code_format #(.LANE_AW(LANE_AW), .AW(AW)) u_fmt (
         .col      (col_q[g]),
         .odd      (odd_q[g]),
         .even     (even_q[g]),
         .wide     (wide),
         .line_hi  (o_hi[g]),
         .line_lo  (o_lo[g]),
         .col_byte (o_col[g])
      );
   end

   assign blk0_line_hi = o_hi[0];
   assign blk0_line_lo = o_lo[0];
   assign blk0_col     = o_col[0];
   assign blk1_line_hi = o_hi[1];
   assign blk1_line_lo = o_lo[1];
   assign blk1_col     = o_col[1];

endmodule

module ecc_stream_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       clr,
   input logic       mode_q,
   input logic       busy,
   input logic       done,
   input logic [7:0] b0_hi,
   input logic [7:0] b0_lo,
   input logic [7:0] b0_col,
   input logic [7:0] b1_hi,
   input logic [7:0] b1_lo,
   input logic [7:0] b1_col
);

   logic [47:0] all_b;
   assign all_b = {b0_hi, b0_lo, b0_col, b1_hi, b1_lo, b1_col};

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (all_b == '0) && !done);

   // R9
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> done);

   // R9
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   // R8
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !clr) |=> $stable(all_b));

   // R7
   wide_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |-> ({b1_hi, b1_lo, b1_col} == '0));

   // R6
   narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (b0_col[1:0] == 2'b00) && (b1_col[1:0] == 2'b00));

endmodule

bind ecc_stream_gen ecc_stream_gen_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .clr    (ecc_clr),
   .mode_q (mode_q),
   .busy   (busy),
   .done   (done),
   .b0_hi  (blk0_line_hi),
   .b0_lo  (blk0_line_lo),
   .b0_col (blk0_col),
   .b1_hi  (blk1_line_hi),
   .b1_lo  (blk1_line_lo),
   .b1_col (blk1_col)
);

// File: tb/ecc_stream_gen_tb.sv
`timescale 1ns/1ps
module ecc_stream_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ecc_clr;
   logic       mode_wide;
   logic       in_valid;
   logic [7:0] in_data;
   logic [7:0] blk0_line_hi, blk0_line_lo, blk0_col;
   logic [7:0] blk1_line_hi, blk1_line_lo, blk1_col;
   logic       done;

   always #5 clk = ~clk;

   ecc_stream_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ecc_clr      (ecc_clr),
      .mode_wide    (mode_wide),
      .in_valid     (in_valid),
      .in_data      (in_data),
      .blk0_line_hi (blk0_line_hi),
      .blk0_line_lo (blk0_line_lo),
      .blk0_col     (blk0_col),
      .blk1_line_hi (blk1_line_hi),
      .blk1_line_lo (blk1_line_lo),
      .blk1_col     (blk1_col),
      .done         (done)
   );

   int n_vec = 0;
   int n_bad = 0;

   logic [7:0] stim [512];
   logic [7:0] x_hi [2];
   logic [7:0] x_lo [2];
   logic [7:0] x_cb [2];

   task automatic cmp(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // Expected codes, computed from the layout rules R4..R7
   function automatic void compute(input bit wide);
      logic [7:0] col [2];
      logic [8:0] od  [2];
      logic [8:0] ev  [2];
      for (int l = 0; l < 2; l++) begin
         col[l] = '0; od[l] = '0; ev[l] = '0;
      end
      for (int i = 0; i < 512; i++) begin
         int   ln;
         logic rp;
         ln = wide ? 0 : i / 256;
         rp = ^stim[i];
         col[ln] = col[ln] ^ stim[i];
         for (int k = 0; k < 9; k++) begin
            if (rp) begin
               if (((i >> k) & 1) == 1) od[ln][k] = ~od[ln][k];
               else                     ev[ln][k] = ~ev[ln][k];
            end
         end
      end
      for (int l = 0; l < 2; l++) begin
         logic [17:0] lb;
         logic [5:0]  cp;
         int          kmax;
         lb   = '0;
         kmax = (wide && l == 0) ? 9 : 8;
         for (int k = 0; k < kmax; k++) begin
            lb[2*k]   = ev[l][k];
            lb[2*k+1] = od[l][k];
         end
         cp[0] = col[l][0] ^ col[l][2] ^ col[l][4] ^ col[l][6];
         cp[1] = col[l][1] ^ col[l][3] ^ col[l][5] ^ col[l][7];
         cp[2] = col[l][0] ^ col[l][1] ^ col[l][4] ^ col[l][5];
         cp[3] = col[l][2] ^ col[l][3] ^ col[l][6] ^ col[l][7];
         cp[4] = col[l][0] ^ col[l][1] ^ col[l][2] ^ col[l][3];
         cp[5] = col[l][4] ^ col[l][5] ^ col[l][6] ^ col[l][7];
         x_hi[l] = lb[15:8];
         x_lo[l] = lb[7:0];
         x_cb[l] = {cp, lb[17:16]};
      end
   endfunction

   task automatic check_codes(input string req);
      cmp(req, "blk0_line_hi", blk0_line_hi, x_hi[0]);
      cmp(req, "blk0_line_lo", blk0_line_lo, x_lo[0]);
      cmp(req, "blk0_col",     blk0_col,     x_cb[0]);
      cmp(req, "blk1_line_hi", blk1_line_hi, x_hi[1]);
      cmp(req, "blk1_line_lo", blk1_line_lo, x_lo[1]);
      cmp(req, "blk1_col",     blk1_col,     x_cb[1]);
   endtask

   task automatic check_zero(input string req);
      for (int l = 0; l < 2; l++) begin
         x_hi[l] = '0; x_lo[l] = '0; x_cb[l] = '0;
      end
      check_codes(req);
      cmp(req, "done", {7'd0, done}, 8'd0);
   endtask

   // All tasks start just after a falling edge and end at one
   task automatic feed(input logic [7:0] b, input logic v);
      in_valid = v;
      in_data  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic strobe(input bit wide, input bit with_byte);
      ecc_clr   = 1'b1;
      mode_wide = wide;
      in_valid  = with_byte;
      in_data   = 8'hA5;
      @(negedge clk);
      ecc_clr  = 1'b0;
      in_valid = 1'b0;
      check_zero("R2");
   endtask

   task automatic fill(input int kind, input int p);
      for (int i = 0; i < 512; i++) begin
         case (kind)
            0:       stim[i] = 8'h00;
            1:       stim[i] = 8'(i);
            2:       stim[i] = 8'((i * 73 + 29) ^ (i >> 3) ^ (i * i));
            3:       stim[i] = 8'hFF;
            default: stim[i] = (i == p) ? 8'(1 << (p % 8)) : 8'h00;
         endcase
      end
   endtask

   task automatic run_stream(input bit wide, input bit gaps,
                             input bit flip, input bit pre, input string req);
      if (pre) begin
         strobe(~wide, 1'b0);
         for (int i = 0; i < 100; i++) feed(8'(i * 13 + 7), 1'b1);
      end
      strobe(wide, pre);
      compute(wide);
      for (int i = 0; i < 512; i++) begin
         if (gaps && (i % 5 == 2)) feed(8'(i) ^ 8'hC3, 1'b0);
         if (flip && i == 300) mode_wide = ~wide;
         if (i == 511) cmp("R9", "done early", {7'd0, done}, 8'd0);
         feed(stim[i], 1'b1);
      end
      cmp("R9", "done", {7'd0, done}, 8'd1);
      check_codes(req);
      for (int i = 0; i < 20; i++) feed(stim[i] ^ 8'h5A, 1'b1);
      check_codes("R8");
      cmp("R9", "done held", {7'd0, done}, 8'd1);
      mode_wide = wide;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      ecc_clr   = 1'b0;
      mode_wide = 1'b0;
      in_valid  = 1'b0;
      in_data   = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_zero("R1");
      for (int i = 0; i < 50; i++) feed(8'(i + 1), 1'b1);
      check_zero("R1");

      for (int w = 0; w < 2; w++) begin
         for (int kind = 0; kind < 4; kind++) begin
            fill(kind, 0);
            run_stream(w[0], 1'b0, 1'b0, 1'b0, w ? "R7" : "R6");
         end
         fill(2, 0);
         run_stream(w[0], 1'b1, 1'b0, 1'b0, "R3");
         run_stream(w[0], 1'b0, 1'b1, 1'b0, "R10");
         run_stream(w[0], 1'b0, 1'b0, 1'b1, "R2");
         // single set bit swept over positions: R4 and R5
         for (int p = 0; p < 512; p += 37) begin
            fill(4, p);
            run_stream(w[0], 1'b0, 1'b0, 1'b0, "R5");
         end
         fill(4, 255); run_stream(w[0], 1'b0, 1'b0, 1'b0, "R4");
         fill(4, 256); run_stream(w[0], 1'b0, 1'b0, 1'b0, "R4");
         fill(4, 511); run_stream(w[0], 1'b0, 1'b0, 1'b0, "R5");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule